// File: doc/BRIEF.md
# PWM Output Skew Delay Unit

This block sits between a multichannel PWM modulator and the output pins. It delays PWM edges by whole master-clock cycles in two stacked ways. A skew setting holds back the negative leg of every differential pair relative to its positive leg. A group offset setting holds back both legs of each A-group pair relative to the matching B-group pair. As a result, the negative legs of the A group carry the sum of both delays.

Both settings share one 8-bit control register. The register takes writes only while the power-down input is high, and it can be read at any time. While power-down is high, all delay lines are cleared and every PWM output is driven low. This prevents stale edges from appearing when the modulators restart. Every output passes through one register stage, so each path has one cycle of base latency on top of its programmed delay.

Top module: `pwm_skew_delay`

## Requirements
- R1: The control register holds the skew field in bits 7:5 and the group offset field in bits 4:0. `rd_data_o` returns the held value at all times, whatever the state of power-down.
- R2: A synchronous active-high reset clears the register to 0x00 and drives every PWM output low.
- R3: A write (`wr_en_i` high) is stored on the next clock edge only while `pdn_i` is high. A write while `pdn_i` is low leaves the register unchanged.
- R4: Each B-group positive output follows its input with a latency of exactly 1 cycle.
- R5: Each B-group negative output follows its input with a latency of 1 + S cycles, where S is the skew field (0 to 7).
- R6: Each A-group positive output follows its input with a latency of 1 + G cycles, where G is the group offset field (0 to 31).
- R7: Each A-group negative output follows its input with a latency of 1 + G + S cycles. At the largest settings this is 39 cycles.
- R8: The single skew setting applies to every pair of both groups at the same time.
- R9: While `pdn_i` is high, all outputs are low on the following cycle. Delay line contents are cleared, so edges captured before power-down never appear after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM master clock |
| rst | input | 1 | Synchronous active-high reset |
| pdn_i | input | 1 | Modulator power-down flag; enables register writes and clears delay lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data: [7:5] skew, [4:0] group offset |
| rd_data_o | output | 8 | Register readback |
| a_pos_i | input | PAIRS | A-group positive legs from the modulator |
| a_neg_i | input | PAIRS | A-group negative legs from the modulator |
| b_pos_i | input | PAIRS | B-group positive legs from the modulator |
| b_neg_i | input | PAIRS | B-group negative legs from the modulator |
| a_pos_o | output | PAIRS | Delayed A-group positive legs |
| a_neg_o | output | PAIRS | Delayed A-group negative legs |
| b_pos_o | output | PAIRS | Delayed B-group positive legs |
| b_neg_o | output | PAIRS | Delayed B-group negative legs |

## Verification
The assertions check the following on every cycle:
- the register gate: a write accepted during power-down, and a write ignored outside it;
- the reset value of the register;
- outputs forced low during power-down;
- the one-cycle pass-through of the B-group positive legs.

The stacked latencies for the other three legs depend on the programmed fields, so only the bench's step-response scenarios can show them. These scenarios cover zero, single-step, mid-range and maximum settings. The bench also shows that pulses held in the delay lines are discarded when power-down is asserted.

// File: rtl/pwm_skew_pkg.sv
`timescale 1ns/1ps
package pwm_skew_pkg;
  localparam int SKEW_W = 3;
  localparam int GRP_W  = 5;
  localparam int CFG_W  = SKEW_W + GRP_W;

  // Field layout of the control register: skew in the upper bits.
  typedef struct packed {
    logic [SKEW_W-1:0] skew;
    logic [GRP_W-1:0]  grp;
  } skew_cfg_t;
endpackage

// File: rtl/skew_ctrl_reg.sv
`timescale 1ns/1ps
module skew_ctrl_reg
  import pwm_skew_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             pdn_i,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output skew_cfg_t        cfg_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o <= '0;
    end else if (wr_en_i && pdn_i) begin
      cfg_o <= skew_cfg_t'(wr_data_i);
    end
  end
endmodule

// File: rtl/skew_tap_line.sv
`timescale 1ns/1ps
module skew_tap_line #(
  parameter int WIDTH = 3,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o
);
  localparam int DEPTH = (1 << SEL_W) - 1;

  logic [WIDTH-1:0] stage [DEPTH];
  logic [WIDTH-1:0] taps  [DEPTH+1];

  always_ff @(posedge clk) begin
    if (clr_i) begin
      for (int k = 0; k < DEPTH; k++) stage[k] <= '0;
    end else begin
      stage[0] <= din_i;
      for (int k = 1; k < DEPTH; k++) stage[k] <= stage[k-1];
    end
  end

  // Tap 0 bypasses the line; tap k reads the k-th stage.
  assign taps[0] = din_i;
  for (genvar t = 1; t <= DEPTH; t++) begin : g_tap
    assign taps[t] = stage[t-1];
  end

  assign dout_o = taps[sel_i];
endmodule

// File: rtl/pwm_skew_delay.sv
`timescale 1ns/1ps
module pwm_skew_delay
  import pwm_skew_pkg::*;
#(
  parameter int PAIRS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pdn_i,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output logic [CFG_W-1:0] rd_data_o,
  input  logic [PAIRS-1:0] a_pos_i,
  input  logic [PAIRS-1:0] a_neg_i,
  input  logic [PAIRS-1:0] b_pos_i,
  input  logic [PAIRS-1:0] b_neg_i,
  output logic [PAIRS-1:0] a_pos_o,
  output logic [PAIRS-1:0] a_neg_o,
  output logic [PAIRS-1:0] b_pos_o,
  output logic [PAIRS-1:0] b_neg_o
);
  skew_cfg_t        cfg;
  logic             clr;
  logic [PAIRS-1:0] b_neg_d, a_neg_s, a_neg_d, a_pos_d;

  assign clr = rst | pdn_i;

  skew_ctrl_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .pdn_i     (pdn_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg)
  );

  assign rd_data_o = cfg;

  // Skew on the negative legs of both groups.
  skew_tap_line #(.WIDTH(PAIRS), .SEL_W(SKEW_W)) u_b_neg_skew (
    .clk(clk), .clr_i(clr), .sel_i(cfg.skew), .din_i(b_neg_i), .dout_o(b_neg_d)
  );
  skew_tap_line #(.WIDTH(PAIRS), .SEL_W(SKEW_W)) u_a_neg_skew (
    .clk(clk), .clr_i(clr), .sel_i(cfg.skew), .din_i(a_neg_i), .dout_o(a_neg_s)
  );

  // Group offset on both legs of the A group, stacked after the skew.
  skew_tap_line #(.WIDTH(PAIRS), .SEL_W(GRP_W)) u_a_neg_grp (
    .clk(clk), .clr_i(clr), .sel_i(cfg.grp), .din_i(a_neg_s), .dout_o(a_neg_d)
  );
  skew_tap_line #(.WIDTH(PAIRS), .SEL_W(GRP_W)) u_a_pos_grp (
    .clk(clk), .clr_i(clr), .sel_i(cfg.grp), .din_i(a_pos_i), .dout_o(a_pos_d)
  );

  // Registered outputs, held low during power-down.
  always_ff @(posedge clk) begin
    if (clr) begin
      a_pos_o <= '0;
      a_neg_o <= '0;
      b_pos_o <= '0;
      b_neg_o <= '0;
    end else begin
      a_pos_o <= a_pos_d;
      a_neg_o <= a_neg_d;
      b_pos_o <= b_pos_i;
      b_neg_o <= b_neg_d;
    end
  end
endmodule

// File: rtl/pwm_skew_delay_chk.sv
`timescale 1ns/1ps
module pwm_skew_delay_chk
  import pwm_skew_pkg::*;
#(
  parameter int PAIRS = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             pdn_i,
  input logic             wr_en_i,
  input logic [CFG_W-1:0] wr_data_i,
  input logic [CFG_W-1:0] rd_data_o,
  input logic [PAIRS-1:0] b_pos_i,
  input logic [PAIRS-1:0] a_pos_o,
  input logic [PAIRS-1:0] a_neg_o,
  input logic [PAIRS-1:0] b_pos_o,
  input logic [PAIRS-1:0] b_neg_o
);
  // R2
  reset_clears_cfg_chk: assert property (@(posedge clk)
    rst |=> (rd_data_o == '0));

  // R3
  write_taken_in_pdn_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && pdn_i) |=> (rd_data_o == $past(wr_data_i)));

  // R3
  write_ignored_when_live_chk: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en_i && pdn_i)) |=> $stable(rd_data_o));

  // R9
  pdn_forces_low_chk: assert property (@(posedge clk) disable iff (rst)
    pdn_i |=> ((a_pos_o | a_neg_o | b_pos_o | b_neg_o) == '0));

  // R4
  b_pos_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !pdn_i |=> (b_pos_o == $past(b_pos_i)));
endmodule

bind pwm_skew_delay pwm_skew_delay_chk #(.PAIRS(PAIRS)) chk_i (
  .clk(clk), .rst(rst), .pdn_i(pdn_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o), .b_pos_i(b_pos_i), .a_pos_o(a_pos_o), .a_neg_o(a_neg_o),
  .b_pos_o(b_pos_o), .b_neg_o(b_neg_o)
);

// File: tb/pwm_skew_delay_tb_top.sv
`timescale 1ns/1ps
module pwm_skew_delay_tb_top;
  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pdn = 1'b1;
  logic         wr_en = 1'b0;
  logic [7:0]   wr_data = '0;
  logic [7:0]   rd_data;
  logic [N-1:0] a_pos_i = '0, a_neg_i = '0, b_pos_i = '0, b_neg_i = '0;
  logic [N-1:0] a_pos_o, a_neg_o, b_pos_o, b_neg_o;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pwm_skew_delay #(.PAIRS(N)) dut_i (
    .clk(clk), .rst(rst), .pdn_i(pdn), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .a_pos_i(a_pos_i), .a_neg_i(a_neg_i), .b_pos_i(b_pos_i),
    .b_neg_i(b_neg_i), .a_pos_o(a_pos_o), .a_neg_o(a_neg_o), .b_pos_o(b_pos_o),
    .b_neg_o(b_neg_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(rd_data == 8'h00, "R2 cfg reset", rd_data, 0);
    check({a_pos_o, a_neg_o, b_pos_o, b_neg_o} == '0, "R2 outputs reset",
          {a_pos_o, a_neg_o, b_pos_o, b_neg_o}, 0);
  endtask

  task automatic t_reg_gate;
    pdn = 1'b1;
    write_cfg(8'hA5);
    check(rd_data == 8'hA5, "R3 write in power-down", rd_data, 8'hA5);
    check(rd_data[7:5] == 3'd5 && rd_data[4:0] == 5'd5, "R1 field layout", rd_data, 8'hA5);
    @(negedge clk); pdn = 1'b0;
    write_cfg(8'h3C);
    check(rd_data == 8'hA5, "R3 write ignored when live", rd_data, 8'hA5);
    check(rd_data == 8'hA5, "R1 readback while live", rd_data, 8'hA5);
    @(negedge clk); pdn = 1'b1;
  endtask

  // Step all inputs high and record the first cycle each output goes high.
  task automatic t_latency(input int s, input int g);
    int fap[N], fan[N], fbp[N], fbn[N];
    pdn = 1'b1;
    write_cfg({s[2:0], g[4:0]});
    check(rd_data == {s[2:0], g[4:0]}, "R1 program", rd_data, {s[2:0], g[4:0]});
    @(negedge clk); pdn = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) begin fap[i] = 0; fan[i] = 0; fbp[i] = 0; fbn[i] = 0; end
    a_pos_i = '1; a_neg_i = '1; b_pos_i = '1; b_neg_i = '1;
    for (int cyc = 1; cyc <= 45; cyc++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        if (a_pos_o[i] && fap[i] == 0) fap[i] = cyc;
        if (a_neg_o[i] && fan[i] == 0) fan[i] = cyc;
        if (b_pos_o[i] && fbp[i] == 0) fbp[i] = cyc;
        if (b_neg_o[i] && fbn[i] == 0) fbn[i] = cyc;
      end
    end
    for (int i = 0; i < N; i++) begin
      check(fbp[i] == 1,         "R4 B+ latency", fbp[i], 1);
      check(fbn[i] == 1 + s,     "R5 B- latency", fbn[i], 1 + s);
      check(fap[i] == 1 + g,     "R6 A+ latency", fap[i], 1 + g);
      check(fan[i] == 1 + g + s, "R7 A- latency", fan[i], 1 + g + s);
    end
    // R8: every pair sees the same skew
    for (int i = 1; i < N; i++) begin
      check(fbn[i] == fbn[0] && fan[i] == fan[0], "R8 skew shared", fan[i], fan[0]);
    end
    a_pos_i = '0; a_neg_i = '0; b_pos_i = '0; b_neg_i = '0;
    repeat (45) @(negedge clk);
    pdn = 1'b1;
  endtask

  task automatic t_stale_clear;
    bit clean = 1'b1;
    pdn = 1'b1;
    write_cfg(8'hFF);
    @(negedge clk); pdn = 1'b0;
    repeat (2) @(negedge clk);
    a_pos_i = '1; a_neg_i = '1;
    repeat (2) @(negedge clk);
    a_pos_i = '0; a_neg_i = '0;
    repeat (5) @(negedge clk);
    pdn = 1'b1;
    repeat (3) @(negedge clk);
    check({a_pos_o, a_neg_o, b_pos_o, b_neg_o} == '0, "R9 low in power-down",
          {a_pos_o, a_neg_o, b_pos_o, b_neg_o}, 0);
    pdn = 1'b0;
    for (int cyc = 0; cyc < 45; cyc++) begin
      @(negedge clk);
      if ((a_pos_o | a_neg_o) != '0) clean = 1'b0;
    end
    check(clean, "R9 no stale edges after release", clean, 1);
    pdn = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_reg_gate();
    t_latency(0, 0);
    t_latency(1, 0);
    t_latency(0, 1);
    t_latency(3, 6);
    t_latency(7, 31);
    t_stale_clear();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule